// File: doc/BRIEF.md
# Frame Preemption Verify Controller

This block runs the verification handshake that a MAC merge sublayer performs before it lets preemptible traffic be split into fragments. Once armed, it asks the transmit MAC to send a verify frame by raising a one-cycle request strobe. It then waits for a response from the receive MAC. The wait is timed by a counter that runs in wireside clock cycles. A typical programmed limit is 1,250,000, which is 10 ms at a 125 MHz gigabit wireside clock. A wait that expires without a response leads to a fresh request, a bounded number of times, before the block gives up.

The outcome is reported on four sticky status flags: verified, failed, respond error and verify error. An 8-bit preemptible traffic-class mask, one bit per class, is forwarded to the transmit path only in two cases: after verification has succeeded, or when verification is switched off. Otherwise the forwarded mask is zero. A link-fail control input holds the handshake in reset while high, and releasing it starts a new attempt. The block does anything only while both the global preemption enable and the per-port enable are high.

Top module: `fp_verify_ctrl`

## Requirements
- R1: While either `glb_enable` or `port_enable` is low, no request is issued, all four status flags are 0 and `tx_preempt_mask` is 0. When both enables become high again, a new attempt starts.
- R2: While `link_fail` is 1, the controller stays idle, issues no request and clears all four status flags. On the first clock edge after `link_fail` returns to 0 with `verify_off` low, `verify_req` goes high for exactly one cycle.
- R3: After a request, the wait lasts `verify_limit` cycles, with a limit of 0 treated as 1. An unanswered request is therefore followed by the next request `verify_limit`+1 cycles later.
- R4: After an unanswered request, up to 3 further requests are made. When the wait after the fourth request expires, `st_failed` becomes 1 and no more requests follow.
- R5: A response with `rsp_is_reply`=1 that arrives in the request cycle or during a wait sets `st_verified` and ends the attempt. A response that arrives in the same cycle the wait expires counts as a success. A response that arrives in the cycle of a retry request is also accepted.
- R6: A response with `rsp_is_reply`=0 sets `st_verify_err`, and the attempt continues as if nothing had arrived.
- R7: A response with `rsp_is_reply`=1 that arrives while idle, verified or failed sets `st_resp_err` and does not change the verified or failed state.
- R8: With `verify_off`=1, no request is issued and `class_mask` is forwarded directly to `tx_preempt_mask`.
- R9: `tx_preempt_mask` equals `class_mask` when the block is enabled and either `st_verified`=1 or `verify_off`=1. Otherwise it is 0. While verified, a change of `class_mask` appears on the output in the same cycle.
- R10: The status flags stay set until `link_fail` is raised or the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wireside clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_enable | input | 1 | Global preemption enable |
| port_enable | input | 1 | Per-port preemption enable |
| link_fail | input | 1 | 1 holds the handshake in reset; releasing it starts an attempt |
| verify_off | input | 1 | Skip the handshake |
| class_mask | input | NCLS (8) | Preemptible traffic classes, one bit each |
| verify_limit | input | CNT_W (24) | Wait length in wireside clock cycles |
| rsp_seen | input | 1 | One-cycle pulse: a verify-type frame was received |
| rsp_is_reply | input | 1 | With `rsp_seen`: 1 = response type, 0 = unexpected type |
| verify_req | output | 1 | One-cycle strobe asking the transmit MAC to send a verify frame |
| st_verified | output | 1 | Handshake succeeded |
| st_failed | output | 1 | All requests timed out |
| st_resp_err | output | 1 | Response received while none was expected |
| st_verify_err | output | 1 | Frame of unexpected type received |
| tx_preempt_mask | output | NCLS (8) | Effective preemptible-class mask for the transmit path |

## Verification
The sharpest collision is a response that lands in the final cycle of a wait, the same cycle the timeout counter expires. The bench answers the first request exactly `verify_limit` cycles after the request strobe and expects a single request and the verified flag. A second case answers one cycle later, in the cycle of the retry request. There it expects two requests and still success. The bench also checks a response against a clear by `link_fail` and against a disable, and confirms that reset wins and clears every flag.

// File: rtl/fp_verify_pkg.sv
package fp_verify_pkg;
  typedef enum logic [2:0] {
    VS_IDLE = 3'd0,
    VS_SEND = 3'd1,
    VS_WAIT = 3'd2,
    VS_DONE = 3'd3,
    VS_FAIL = 3'd4
  } vstate_e;
endpackage

// File: rtl/fp_verify_timer.sv
module fp_verify_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_en;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    // a zero limit behaves like a limit of one
    expire  = run && (cnt_inc >= {1'b0, limit});
    cnt_en  = clr || run;
    cnt_d   = cnt_q;
    if (clr)          cnt_d = '0;
    else if (!expire) cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/fp_verify_seq.sv
module fp_verify_seq
  import fp_verify_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hold,
  input  logic skip,
  input  logic rsp_valid,
  input  logic rsp_good,
  input  logic expire,
  output logic req,
  output logic tmr_clr,
  output logic tmr_run,
  output logic verified,
  output logic failed,
  output logic rsp_err,
  output logic ver_err
);
  localparam int TW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  vstate_e       st_q, st_d;
  logic [TW-1:0] tries_q, tries_d;
  logic          armed_q, armed_d;
  logic          rerr_q, rerr_d, verr_q, verr_d;
  logic          kill, expecting, idle_like;

  always_comb begin
    kill      = !active || hold;
    expecting = (st_q == VS_SEND) || (st_q == VS_WAIT);
    idle_like = (st_q == VS_IDLE) || (st_q == VS_DONE) || (st_q == VS_FAIL);
    st_d      = st_q;
    tries_d   = tries_q;
    armed_d   = armed_q;
    rerr_d    = rerr_q;
    verr_d    = verr_q;
    if (kill) begin
      st_d    = VS_IDLE;
      tries_d = '0;
      armed_d = 1'b1;
      rerr_d  = 1'b0;
      verr_d  = 1'b0;
    end else begin
      if (rsp_valid && !rsp_good)             verr_d = 1'b1;
      if (rsp_valid && rsp_good && idle_like) rerr_d = 1'b1;
      unique case (st_q)
        VS_IDLE: if (armed_q && !skip) begin
          st_d    = VS_SEND;
          armed_d = 1'b0;
          tries_d = '0;
        end
        VS_SEND: st_d = (rsp_valid && rsp_good) ? VS_DONE : VS_WAIT;
        VS_WAIT: begin
          if (rsp_valid && rsp_good) st_d = VS_DONE;
          else if (expire) begin
            if (tries_q == TW'(MAX_RETRY)) st_d = VS_FAIL;
            else begin
              st_d    = VS_SEND;
              tries_d = tries_q + 1'b1;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= VS_IDLE;
      tries_q <= '0;
      armed_q <= 1'b1;
      rerr_q  <= 1'b0;
      verr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      tries_q <= tries_d;
      armed_q <= armed_d;
      rerr_q  <= rerr_d;
      verr_q  <= verr_d;
    end
  end

  assign req      = (st_q == VS_SEND);
  assign tmr_run  = (st_q == VS_WAIT);
  assign tmr_clr  = !tmr_run;
  assign verified = (st_q == VS_DONE);
  assign failed   = (st_q == VS_FAIL);
  assign rsp_err  = rerr_q;
  assign ver_err  = verr_q;

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!req && !verified && !failed && !rsp_err && !ver_err));
  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R4
  fail_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !kill) |=> (failed && !req));
  // R5
  wait_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && expecting && rsp_valid && rsp_good) |=> verified);
  // R6
  bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && rsp_valid && !rsp_good) |=> ver_err);
  // R7
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && verified && rsp_valid && rsp_good) |=> (rsp_err && verified));
endmodule

// File: rtl/fp_verify_ctrl.sv
module fp_verify_ctrl #(
  parameter int CNT_W     = 24,
  parameter int NCLS      = 8,
  parameter int MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_enable,
  input  logic             port_enable,
  input  logic             link_fail,
  input  logic             verify_off,
  input  logic [NCLS-1:0]  class_mask,
  input  logic [CNT_W-1:0] verify_limit,
  input  logic             rsp_seen,
  input  logic             rsp_is_reply,
  output logic             verify_req,
  output logic             st_verified,
  output logic             st_failed,
  output logic             st_resp_err,
  output logic             st_verify_err,
  output logic [NCLS-1:0]  tx_preempt_mask
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       active, expire, tmr_clr, tmr_run;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];
  assign active    = glb_enable && port_enable;

  fp_verify_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (tmr_clr),
    .run    (tmr_run),
    .limit  (verify_limit),
    .expire (expire)
  );

  fp_verify_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .active    (active),
    .hold      (link_fail),
    .skip      (verify_off),
    .rsp_valid (rsp_seen),
    .rsp_good  (rsp_is_reply),
    .expire    (expire),
    .req       (verify_req),
    .tmr_clr   (tmr_clr),
    .tmr_run   (tmr_run),
    .verified  (st_verified),
    .failed    (st_failed),
    .rsp_err   (st_resp_err),
    .ver_err   (st_verify_err)
  );

  always_comb begin
    tx_preempt_mask = '0;
    if (active && (st_verified || verify_off)) tx_preempt_mask = class_mask;
  end

  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_preempt_mask != '0) |-> (active && (st_verified || verify_off)));
  // R8
  skip_noreq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (verify_off && !st_verified && !verify_req && !tmr_run) |=> !verify_req);
endmodule

// File: tb/fp_verify_ctrl_tb.sv
module fp_verify_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 24;
  localparam int NCLS       = 8;
  localparam int WIN        = 60;

  typedef struct packed {
    logic [7:0] lim;
    logic       skip;
    logic [3:0] ans;    // which request to answer, 0 = none
    logic [3:0] dly;    // cycles after the request strobe
    logic       good;
    logic       e_ok;
    logic       e_fail;
    logic       e_verr;
    logic [3:0] e_nreq;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'd4, 1'b0, 4'd1, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
    '{8'd4, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    '{8'd4, 1'b0, 4'd3, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},
    '{8'd4, 1'b0, 4'd1, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
    '{8'd4, 1'b0, 4'd1, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
    '{8'd4, 1'b1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},
    '{8'd4, 1'b0, 4'd1, 4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4},
    '{8'd0, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    '{8'd9, 1'b0, 4'd2, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n, glb_enable, port_enable, link_fail, verify_off;
  logic [NCLS-1:0]  class_mask;
  logic [CNT_W-1:0] verify_limit;
  logic             rsp_seen, rsp_is_reply;
  logic             verify_req, st_verified, st_failed, st_resp_err, st_verify_err;
  logic [NCLS-1:0]  tx_preempt_mask;

  int n_chk = 0;
  int n_err = 0;
  int nreq;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_verify_ctrl #(.CNT_W(CNT_W), .NCLS(NCLS), .MAX_RETRY(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .glb_enable(glb_enable), .port_enable(port_enable),
    .link_fail(link_fail), .verify_off(verify_off), .class_mask(class_mask),
    .verify_limit(verify_limit), .rsp_seen(rsp_seen), .rsp_is_reply(rsp_is_reply),
    .verify_req(verify_req), .st_verified(st_verified), .st_failed(st_failed),
    .st_resp_err(st_resp_err), .st_verify_err(st_verify_err),
    .tx_preempt_mask(tx_preempt_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // counts request strobes over a window and answers the chosen one
  task automatic run_window(input int ans, input int dly, input logic good, input int ncyc);
    int cd;
    cd   = -1;
    nreq = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      rsp_seen = 1'b0;
      if (verify_req) begin
        nreq++;
        if (nreq == ans) cd = dly;
      end
      if (cd == 0) begin
        rsp_seen     = 1'b1;
        rsp_is_reply = good;
      end
      if (cd >= 0) cd--;
    end
    @(negedge clk);
    rsp_seen = 1'b0;
  endtask

  task automatic restart(input int lim, input logic skip);
    @(negedge clk);
    link_fail    = 1'b1;
    verify_limit = CNT_W'(lim);
    verify_off   = skip;
    repeat (2) @(negedge clk);
    link_fail = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; glb_enable = 1'b1; port_enable = 1'b1; link_fail = 1'b1;
    verify_off = 1'b0; class_mask = 8'hA5; verify_limit = 24'd4;
    rsp_seen = 1'b0; rsp_is_reply = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset req", 32'(verify_req), 0);
    chk("R1 reset status", 32'({st_verified, st_failed, st_resp_err, st_verify_err}), 0);
    chk("R9 reset mask", 32'(tx_preempt_mask), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of scenarios
    foreach (VECS[i]) begin
      restart(int'(VECS[i].lim), VECS[i].skip);
      run_window(int'(VECS[i].ans), int'(VECS[i].dly), VECS[i].good, WIN);
      chk($sformatf("R5 v%0d verified", i), 32'(st_verified), 32'(VECS[i].e_ok));
      chk($sformatf("R4 v%0d failed", i), 32'(st_failed), 32'(VECS[i].e_fail));
      chk($sformatf("R6 v%0d verify_err", i), 32'(st_verify_err), 32'(VECS[i].e_verr));
      chk($sformatf("R7 v%0d resp_err", i), 32'(st_resp_err), 0);
      chk($sformatf("R3 v%0d requests", i), 32'(nreq), 32'(VECS[i].e_nreq));
      chk($sformatf("R9 v%0d mask", i), 32'(tx_preempt_mask),
          (VECS[i].e_ok || VECS[i].skip) ? 32'hA5 : 32'h0);
    end

    // R2 timing: first request one edge after link_fail release
    @(negedge clk);
    verify_off = 1'b0; verify_limit = 24'd4; link_fail = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R2 held no req", 32'(verify_req), 0);
    end
    link_fail = 1'b0;
    @(negedge clk);
    chk("R2 req after release", 32'(verify_req), 1);
    @(negedge clk);
    chk("R2 req one cycle", 32'(verify_req), 0);
    rsp_seen = 1'b1; rsp_is_reply = 1'b1;
    @(negedge clk);
    rsp_seen = 1'b0;
    chk("R5 verified", 32'(st_verified), 1);
    // R9 mask follows input while verified
    class_mask = 8'h3C;
    #1;
    chk("R9 mask follows", 32'(tx_preempt_mask), 32'h3C);

    // R7 stray response while verified
    @(negedge clk);
    rsp_seen = 1'b1;
    @(negedge clk);
    rsp_seen = 1'b0;
    chk("R7 resp_err verified", 32'(st_resp_err), 1);
    chk("R7 still verified", 32'(st_verified), 1);
    repeat (5) @(negedge clk);
    chk("R10 sticky", 32'({st_verified, st_resp_err}), 32'h3);

    // R10 link_fail clears everything
    link_fail = 1'b1;
    @(negedge clk);
    chk("R10 cleared", 32'({st_verified, st_failed, st_resp_err, st_verify_err}), 0);
    chk("R9 mask cleared", 32'(tx_preempt_mask), 0);

    // R1 disabled block stays quiet, even with skip
    glb_enable = 1'b0; verify_off = 1'b1; link_fail = 1'b0;
    run_window(0, 0, 1'b1, 20);
    chk("R1 glb off req", 32'(nreq), 0);
    chk("R1 glb off mask", 32'(tx_preempt_mask), 0);
    glb_enable = 1'b1; port_enable = 1'b0;
    run_window(0, 0, 1'b1, 20);
    chk("R1 port off req", 32'(nreq), 0);
    chk("R1 port off mask", 32'(tx_preempt_mask), 0);

    // R8 skip: mask passes, response while idle is a respond error
    port_enable = 1'b1;
    run_window(0, 0, 1'b1, 10);
    chk("R8 skip no req", 32'(nreq), 0);
    chk("R8 skip mask", 32'(tx_preempt_mask), 32'h3C);
    rsp_seen = 1'b1; rsp_is_reply = 1'b1;
    @(negedge clk);
    rsp_seen = 1'b0;
    chk("R7 resp_err idle", 32'(st_resp_err), 1);
    chk("R7 idle not verified", 32'(st_verified), 0);

    // R1 re-enable starts a fresh attempt
    verify_off = 1'b0; glb_enable = 1'b0;
    @(negedge clk);
    chk("R1 disable clears", 32'(st_resp_err), 0);
    glb_enable = 1'b1;
    run_window(0, 0, 1'b1, 8);
    chk("R1 restart req", 32'(nreq >= 1), 1);

    finish_run();
  end
endmodule